// File: doc/BRIEF.md
# Four-Phase Bus Handshake Controller

This block is a clocked controller placed between a bus master and a local device. The master asks for a transfer with one of two strobes: read or write. The controller then runs a full four-phase handshake. It drives a strobe to the device, an enable for the data transceiver and an acknowledge back to the master, and it raises and lowers them in a fixed order for each transfer type. The device answers on a single acknowledge line.

All three inputs are asynchronous to the clock. Each one passes through a flop synchronizer before the sequencer sees it, and every output comes from a register. During a read, an internal phase bit marks the first half of the transfer. Two points of the read then look the same on the pins but call for different next moves, and the phase bit tells them apart. A new transfer cannot raise the device strobe until the device has dropped its acknowledge from the previous one. A sticky error flag records strobe collisions and any input edge that arrives at a point where the sequencer does not expect it. None of the interfaces carry data, so every pin is a plain level signal.

Top module: `bus_hs_ctrl`

## Requirements
- R1: While `rst` is high at a rising edge, all outputs and the internal phase bit are low from the next edge on. After reset the controller stays idle until a strobe arrives.
- R2: Read opening. After the read strobe rises, the phase bit is set first and `dev_stb_o` rises one edge later, which is four rising edges after the strobe changed. The transceiver enable and the bus acknowledge stay low until then, and the phase bit is never set during a write.
- R3: In a read, `xcvr_en_o` rises three edges after `dev_ack_i` rises, and `bus_ack_o` follows one edge after that.
- R4: In a read, `xcvr_en_o` falls three edges after the read strobe falls. The phase bit clears one edge later. `bus_ack_o` and `dev_stb_o` then fall together on the next edge.
- R5: In a write, `xcvr_en_o` rises before `dev_stb_o`, and `dev_stb_o` rises one edge after it.
- R6: In a write, `xcvr_en_o` falls three edges after `dev_ack_i` rises and `bus_ack_o` rises one edge after that. Three edges after the write strobe falls, `bus_ack_o` and `dev_stb_o` fall together.
- R7: With the default two synchronizer stages, the sequencer acts on an input change at the third rising edge after the change. Its outputs are unchanged two edges after the change.
- R8: Once `dev_stb_o` has fallen, it does not rise again while the synchronized `dev_ack_i` is high, even if a new strobe is already waiting. A read strobe held through that wait raises `dev_stb_o` five edges after `dev_ack_i` falls.
- R9: If both strobes are high together after synchronization, `proto_err_o` is set on the following edge and no transfer starts.
- R10: `proto_err_o` is set by an unexpected input edge: `dev_ack_i` rising while `dev_stb_o` is low, `dev_ack_i` falling while it is high, a strobe rising outside idle or release, or a strobe falling before `bus_ack_o` has answered it. An output that has already been raised is not withdrawn because of such an edge.
- R11: `proto_err_o` stays set until reset and is low after reset.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rd_req_i | input | 1 | Read strobe from the bus master (asynchronous) |
| wr_req_i | input | 1 | Write strobe from the bus master (asynchronous) |
| dev_ack_i | input | 1 | Acknowledge from the local device (asynchronous) |
| dev_stb_o | output | 1 | Strobe to the local device |
| xcvr_en_o | output | 1 | Data transceiver enable |
| bus_ack_o | output | 1 | Acknowledge to the bus master |
| proto_err_o | output | 1 | Sticky protocol error flag |

## Verification
Clean read and clean write cycles are sampled edge by edge. This tells the two output orderings apart, and it shows the extra edge that the read's phase bit adds before the device strobe and again before release. A read strobe held while the device acknowledge is still high separates a controller that waits for the acknowledge to drop from one that restarts at once. Colliding strobes, a stray device acknowledge during idle and a read strobe dropped before its acknowledge each show that the error flag responds only to protocol breaks. The last of these also shows that the flag persists and that the raised device strobe is held rather than withdrawn.

// File: rtl/bus_hs_pkg.sv
package bus_hs_pkg;

  // Sequencer states; the read path carries the phase bit, the write path does not.
  typedef enum logic [3:0] {
    HS_IDLE      = 4'd0,
    HS_RD_ARM    = 4'd1,
    HS_RD_STB    = 4'd2,
    HS_RD_XCV    = 4'd3,
    HS_RD_ACK    = 4'd4,
    HS_RD_XOFF   = 4'd5,
    HS_RD_DISARM = 4'd6,
    HS_WR_XCV    = 4'd7,
    HS_WR_STB    = 4'd8,
    HS_WR_XOFF   = 4'd9,
    HS_WR_ACK    = 4'd10,
    HS_RELEASE   = 4'd11
  } hs_state_e;

  // Registered output bundle of the sequencer.
  typedef struct packed {
    logic stb;    // device strobe
    logic xcv;    // transceiver enable
    logic back;   // bus acknowledge
    logic phase;  // read phase bit, resolves coding conflict
  } hs_out_t;

  localparam int unsigned HS_NUM_IN = 3;
  localparam int unsigned HS_IDX_RD = 0;
  localparam int unsigned HS_IDX_WR = 1;
  localparam int unsigned HS_IDX_DA = 2;

  // A strobe may rise only while no transfer is using the outputs.
  function automatic logic hs_strobe_rise_ok(hs_state_e st);
    return (st == HS_IDLE) || (st == HS_RELEASE);
  endfunction

endpackage

// File: rtl/bus_hs_sync.sv
module bus_hs_sync #(
  parameter int unsigned WIDTH  = 3,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);

  localparam int unsigned DEPTH = (STAGES < 1) ? 1 : STAGES;

  generate
    if (DEPTH == 1) begin : g_single
      logic [WIDTH-1:0] flop_q;
      always_ff @(posedge clk) begin
        if (rst) flop_q <= '0;
        else     flop_q <= async_i;
      end
      assign sync_o = flop_q;
    end else begin : g_chain
      for (genvar b = 0; b < WIDTH; b++) begin : g_bit
        logic [DEPTH-1:0] chain_q;
        always_ff @(posedge clk) begin
          if (rst) chain_q <= '0;
          else     chain_q <= {chain_q[DEPTH-2:0], async_i[b]};
        end
        assign sync_o[b] = chain_q[DEPTH-1];
      end
    end
  endgenerate

endmodule

// File: rtl/bus_hs_seq.sv
module bus_hs_seq
  import bus_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rd_i,
  input  logic      wr_i,
  input  logic      ack_i,
  output hs_state_e state_o,
  output hs_out_t   out_o
);

  hs_state_e st_q, st_d;
  hs_out_t   o_q, o_d;

  always_comb begin
    st_d = st_q;
    o_d  = o_q;
    unique case (st_q)
      HS_IDLE: begin
        if (rd_i && !wr_i) begin
          st_d    = HS_RD_ARM;
          o_d.phase = 1'b1;
        end else if (wr_i && !rd_i) begin
          st_d    = HS_WR_XCV;
          o_d.xcv = 1'b1;
        end
      end
      HS_RD_ARM: begin
        st_d    = HS_RD_STB;
        o_d.stb = 1'b1;
      end
      HS_RD_STB: begin
        if (ack_i) begin
          st_d    = HS_RD_XCV;
          o_d.xcv = 1'b1;
        end
      end
      HS_RD_XCV: begin
        st_d     = HS_RD_ACK;
        o_d.back = 1'b1;
      end
      HS_RD_ACK: begin
        if (!rd_i) begin
          st_d    = HS_RD_XOFF;
          o_d.xcv = 1'b0;
        end
      end
      HS_RD_XOFF: begin
        st_d      = HS_RD_DISARM;
        o_d.phase = 1'b0;
      end
      HS_RD_DISARM: begin
        st_d     = HS_RELEASE;
        o_d.back = 1'b0;
        o_d.stb  = 1'b0;
      end
      HS_WR_XCV: begin
        st_d    = HS_WR_STB;
        o_d.stb = 1'b1;
      end
      HS_WR_STB: begin
        if (ack_i) begin
          st_d    = HS_WR_XOFF;
          o_d.xcv = 1'b0;
        end
      end
      HS_WR_XOFF: begin
        st_d     = HS_WR_ACK;
        o_d.back = 1'b1;
      end
      HS_WR_ACK: begin
        if (!wr_i) begin
          st_d     = HS_RELEASE;
          o_d.back = 1'b0;
          o_d.stb  = 1'b0;
        end
      end
      HS_RELEASE: begin
        if (!ack_i) st_d = HS_IDLE;
      end
      default: begin
        st_d = HS_IDLE;
        o_d  = '0;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= HS_IDLE;
      o_q  <= '0;
    end else begin
      st_q <= st_d;
      o_q  <= o_d;
    end
  end

  assign state_o = st_q;
  assign out_o   = o_q;

endmodule

// File: rtl/bus_hs_err.sv
module bus_hs_err
  import bus_hs_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      rd_i,
  input  logic      wr_i,
  input  logic      ack_i,
  input  hs_state_e state_i,
  input  logic      stb_i,
  output logic      err_o
);

  logic rd_prev_q, wr_prev_q, ack_prev_q, err_q;
  logic rd_up, rd_dn, wr_up, wr_dn, ack_up, ack_dn;
  logic collide, bad_ack, bad_rd, bad_wr;

  assign rd_up  = rd_i  & ~rd_prev_q;
  assign rd_dn  = ~rd_i & rd_prev_q;
  assign wr_up  = wr_i  & ~wr_prev_q;
  assign wr_dn  = ~wr_i & wr_prev_q;
  assign ack_up = ack_i & ~ack_prev_q;
  assign ack_dn = ~ack_i & ack_prev_q;

  assign collide = rd_i & wr_i;
  assign bad_ack = (ack_up & ~stb_i) | (ack_dn & stb_i);
  assign bad_rd  = (rd_up & ~hs_strobe_rise_ok(state_i)) |
                   (rd_dn & (state_i != HS_RD_ACK));
  assign bad_wr  = (wr_up & ~hs_strobe_rise_ok(state_i)) |
                   (wr_dn & (state_i != HS_WR_ACK));

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_prev_q  <= 1'b0;
      wr_prev_q  <= 1'b0;
      ack_prev_q <= 1'b0;
      err_q      <= 1'b0;
    end else begin
      rd_prev_q  <= rd_i;
      wr_prev_q  <= wr_i;
      ack_prev_q <= ack_i;
      if (collide || bad_ack || bad_rd || bad_wr) err_q <= 1'b1;
    end
  end

  assign err_o = err_q;

endmodule

// File: rtl/bus_hs_ctrl.sv
module bus_hs_ctrl
  import bus_hs_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic rd_req_i,
  input  logic wr_req_i,
  input  logic dev_ack_i,
  output logic dev_stb_o,
  output logic xcvr_en_o,
  output logic bus_ack_o,
  output logic proto_err_o
);

  logic [HS_NUM_IN-1:0] raw_in, syn_in;
  logic      rd_s, wr_s, ack_s;
  hs_state_e state;
  hs_out_t   outs;
  logic      phase_w;

  assign raw_in[HS_IDX_RD] = rd_req_i;
  assign raw_in[HS_IDX_WR] = wr_req_i;
  assign raw_in[HS_IDX_DA] = dev_ack_i;

  bus_hs_sync #(.WIDTH(HS_NUM_IN), .STAGES(SYNC_STAGES)) u_sync (
    .clk     (clk),
    .rst     (rst),
    .async_i (raw_in),
    .sync_o  (syn_in)
  );

  assign rd_s  = syn_in[HS_IDX_RD];
  assign wr_s  = syn_in[HS_IDX_WR];
  assign ack_s = syn_in[HS_IDX_DA];

  bus_hs_seq u_seq (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_s),
    .wr_i    (wr_s),
    .ack_i   (ack_s),
    .state_o (state),
    .out_o   (outs)
  );

  bus_hs_err u_err (
    .clk     (clk),
    .rst     (rst),
    .rd_i    (rd_s),
    .wr_i    (wr_s),
    .ack_i   (ack_s),
    .state_i (state),
    .stb_i   (outs.stb),
    .err_o   (proto_err_o)
  );

  assign phase_w   = outs.phase;
  assign dev_stb_o = outs.stb;
  assign xcvr_en_o = outs.xcv;
  assign bus_ack_o = outs.back;

endmodule

// File: rtl/bus_hs_ctrl_chk.sv
module bus_hs_ctrl_chk (
  input logic clk,
  input logic rst,
  input logic rd_s,
  input logic wr_s,
  input logic ack_s,
  input logic stb,
  input logic xcv,
  input logic back,
  input logic phase,
  input logic err
);

  AST_RESET_QUIET: assert property (@(posedge clk)
    rst |=> (!stb && !xcv && !back && !phase && !err)); // R1

  AST_RD_STB_AFTER_PHASE: assert property (@(posedge clk) disable iff (rst)
    ($rose(stb) && !xcv) |-> $past(phase)); // R2

  AST_WR_NO_PHASE: assert property (@(posedge clk) disable iff (rst)
    (xcv && !stb) |-> !phase); // R2

  AST_RD_ACK_AFTER_XCV: assert property (@(posedge clk) disable iff (rst)
    ($rose(xcv) && stb) |=> $rose(back)); // R3

  AST_RELEASE_TOGETHER: assert property (@(posedge clk) disable iff (rst)
    $fell(back) |-> $fell(stb)); // R4

  AST_WR_STB_AFTER_XCV: assert property (@(posedge clk) disable iff (rst)
    ($rose(xcv) && !stb) |=> $rose(stb)); // R5

  AST_WR_ACK_AFTER_XOFF: assert property (@(posedge clk) disable iff (rst)
    ($fell(xcv) && !back) |=> $rose(back)); // R6

  AST_HOLD_FOR_ACK_LOW: assert property (@(posedge clk) disable iff (rst)
    (!stb && ack_s && !err) |=> !stb); // R8

  AST_COLLIDE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    (rd_s && wr_s) |=> err); // R9

  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err |=> err); // R11

endmodule

bind bus_hs_ctrl bus_hs_ctrl_chk u_chk (
  .clk   (clk),
  .rst   (rst),
  .rd_s  (rd_s),
  .wr_s  (wr_s),
  .ack_s (ack_s),
  .stb   (dev_stb_o),
  .xcv   (xcvr_en_o),
  .back  (bus_ack_o),
  .phase (phase_w),
  .err   (proto_err_o)
);

// File: tb/test_bus_hs_ctrl.sv
module test_bus_hs_ctrl;

  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 100000;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic rd = 1'b0, wr = 1'b0, ack = 1'b0;
  logic stb, xcv, back, err;
  int   n_chk = 0;
  int   n_fail = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  bus_hs_ctrl i_bus_hs_ctrl (
    .clk         (clk),
    .rst         (rst),
    .rd_req_i    (rd),
    .wr_req_i    (wr),
    .dev_ack_i   (ack),
    .dev_stb_o   (stb),
    .xcvr_en_o   (xcv),
    .bus_ack_o   (back),
    .proto_err_o (err)
  );

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input string what, input logic got, input logic exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %b expected %b", req, what, got, exp);
    end
  endtask

  task automatic do_reset();
    rst = 1'b1; rd = 1'b0; wr = 1'b0; ack = 1'b0;
    step(4);
    rst = 1'b0;
    step(1);
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "stb", stb, 1'b0);
    chk("R1", "xcv", xcv, 1'b0);
    chk("R1", "back", back, 1'b0);
    chk("R1", "err", err, 1'b0);
    step(5);
    chk("R1", "idle stb", stb, 1'b0);
  endtask

  task automatic t_read();
    do_reset();
    rd = 1'b1;
    step(3);
    chk("R2", "stb waits for phase", stb, 1'b0);
    step(1);
    chk("R2", "stb up", stb, 1'b1);
    chk("R2", "xcv low", xcv, 1'b0);
    chk("R2", "back low", back, 1'b0);
    ack = 1'b1;
    step(2);
    chk("R7", "xcv before 3rd edge", xcv, 1'b0);
    step(1);
    chk("R3", "xcv up", xcv, 1'b1);
    chk("R3", "back not yet", back, 1'b0);
    step(1);
    chk("R3", "back up", back, 1'b1);
    rd = 1'b0;
    step(3);
    chk("R4", "xcv down", xcv, 1'b0);
    chk("R4", "back held", back, 1'b1);
    step(1);
    chk("R4", "stb held during phase clear", stb, 1'b1);
    step(1);
    chk("R4", "back down", back, 1'b0);
    chk("R4", "stb down", stb, 1'b0);
    ack = 1'b0;
    step(4);
    chk("R10", "no error on clean read", err, 1'b0);
  endtask

  task automatic t_write();
    do_reset();
    wr = 1'b1;
    step(2);
    chk("R7", "xcv unchanged at 2 edges", xcv, 1'b0);
    step(1);
    chk("R7", "xcv up at 3rd edge", xcv, 1'b1);
    chk("R5", "stb after xcv", stb, 1'b0);
    step(1);
    chk("R5", "stb up", stb, 1'b1);
    ack = 1'b1;
    step(3);
    chk("R6", "xcv down", xcv, 1'b0);
    chk("R6", "back not yet", back, 1'b0);
    step(1);
    chk("R6", "back up", back, 1'b1);
    wr = 1'b0;
    step(2);
    chk("R6", "back held", back, 1'b1);
    step(1);
    chk("R6", "back down", back, 1'b0);
    chk("R6", "stb down", stb, 1'b0);
    ack = 1'b0;
    step(4);
    chk("R10", "no error on clean write", err, 1'b0);
  endtask

  task automatic t_back_to_back();
    do_reset();
    rd = 1'b1;
    step(4);
    ack = 1'b1;
    step(4);
    rd = 1'b0;
    step(5);
    chk("R8", "first read released", stb, 1'b0);
    rd = 1'b1;
    step(6);
    chk("R8", "stb held low while ack high", stb, 1'b0);
    chk("R8", "xcv held low while ack high", xcv, 1'b0);
    ack = 1'b0;
    step(4);
    chk("R8", "stb not yet", stb, 1'b0);
    step(1);
    chk("R8", "stb up after ack low", stb, 1'b1);
    chk("R10", "early next strobe is legal", err, 1'b0);
  endtask

  task automatic t_collide();
    do_reset();
    rd = 1'b1; wr = 1'b1;
    step(2);
    chk("R9", "err not before 3rd edge", err, 1'b0);
    step(1);
    chk("R9", "err set", err, 1'b1);
    step(3);
    chk("R9", "no stb", stb, 1'b0);
    chk("R9", "no xcv", xcv, 1'b0);
  endtask

  task automatic t_stray_ack();
    do_reset();
    ack = 1'b1;
    step(3);
    chk("R10", "ack while stb low", err, 1'b1);
    chk("R10", "stb stays low", stb, 1'b0);
  endtask

  task automatic t_early_release();
    do_reset();
    rd = 1'b1;
    step(4);
    rd = 1'b0;
    step(3);
    chk("R10", "strobe dropped early", err, 1'b1);
    chk("R10", "stb not withdrawn", stb, 1'b1);
    chk("R10", "xcv stays low", xcv, 1'b0);
    step(10);
    chk("R11", "err sticky", err, 1'b1);
    do_reset();
    chk("R11", "err cleared by reset", err, 1'b0);
  endtask

  initial begin
    t_reset();
    t_read();
    t_write();
    t_back_to_back();
    t_collide();
    t_stray_ack();
    t_early_release();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule